// File: doc/BRIEF.md
# Banked Special-Function Register File

This block holds the core control registers of a small 8-bit microcontroller and resolves every data access to one of them. A 7-bit direct offset from the instruction is joined with a bank bit taken from the status register to form an 8-bit data address. The core registers (program-counter low byte, status, pointer, upper-PC latch, interrupt control) are mirrored so that both banks reach the same physical copy. The option register and the two pin-direction registers exist only in bank 1. Offset 00h is an indirect slot: it has no storage of its own and forwards the access to the full 8-bit address held in the pointer register.

Reads are combinational from address to data. Writes, reset requests and the upper-PC load all act on the rising clock edge. The values loaded depend on the kind of reset. A power-on request sets every register to its start value. A request from the external pin or from the watchdog keeps the timeout and power-down flags and a few other bits. The upper-PC latch feeds the program counter's bits 12:8 only when the core asks for a load. Nothing ever flows back into the latch.

Top module: `banked_sfr_file`

## Requirements
- R1: A direct access addresses {status bit 5, offset}. The option register (offset 01h), port-A direction (05h) and port-B direction (06h) are reached only when status bit 5 is 1. With bit 5 at 0, those offsets read 0.
- R2: Offsets 02h (PC low byte), 03h (status), 04h (pointer), 0Ah (upper-PC latch) and 0Bh (interrupt control) access one shared register in either bank.
- R3: An access at offset 00h uses the full 8-bit pointer value as its address, whatever status bit 5 holds.
- R4: If the pointer's low 7 bits are zero, an indirect read returns 0 and an indirect write changes no register.
- R5: Every address not listed in R1 and R2 reads as 0, and a write to it changes no register. Examples are 07h and 87h.
- R6: The upper-PC latch stores 5 bits and reads with bits 7:5 at 0. pc_full[12:8] takes the latch value on the edge where pc_load is high. At any other edge without a reset it holds its value. The latch itself never changes because of pc_load.
- R7: Power-on reset sets status to 18h, the option register to FFh, port-A direction to 1Fh and port-B direction to FFh. It clears the pointer, PC low byte, upper-PC latch, interrupt control and pc_full.
- R8: A pin or watchdog reset clears status bits 7:5 and keeps status bits 4:0. It clears interrupt-control bits 7:1 and keeps bit 0. It keeps the pointer. It clears the PC low byte, the upper-PC latch and pc_full. It sets option to FFh and both direction registers to all ones.
- R9: Power-on reset takes priority over the other resets, and any reset takes priority over a write or a pc_load in the same cycle.
- R10: rd_data follows addr and register contents without a clock. A write becomes visible only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| por_req | input | 1 | Power-on reset request, sampled at the edge |
| pin_rst_req | input | 1 | External-pin reset request, sampled at the edge |
| wdt_rst_req | input | 1 | Watchdog reset request, sampled at the edge |
| addr | input | 7 | Direct offset within the selected bank |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data of the addressed register |
| pc_load | input | 1 | Copy the upper-PC latch into PC bits 12:8 |
| pc_full | output | 13 | {PC upper bits, PC low byte register} |

## Verification
A read result is due in the same cycle its address is applied. The bench therefore drives addr on the falling edge and samples rd_data 2 ns later, well before the next rising edge. Writes, resets and pc_load take effect at the first rising edge after they are driven. The bench's reference model updates at that edge, and the result is checked only in a later read phase. One directed case samples the old value before the edge and the new value after it. pc_full is sampled together with each read, one edge after any load or reset that changes it.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 8;
    localparam int OFF_W  = ADDR_W - 1;
    localparam int PCH_W  = 5;
    localparam int DIRA_W = 5;
    localparam int PC_W   = PCH_W + DATA_W;

    // status bit positions
    localparam int ST_BANK = 5;
    localparam int ST_KEEP_HI = 4;

    localparam logic [OFF_W-1:0] OFF_IND    = 7'h00;
    localparam logic [OFF_W-1:0] OFF_OPTION = 7'h01;
    localparam logic [OFF_W-1:0] OFF_PCL    = 7'h02;
    localparam logic [OFF_W-1:0] OFF_STATUS = 7'h03;
    localparam logic [OFF_W-1:0] OFF_PTR    = 7'h04;
    localparam logic [OFF_W-1:0] OFF_DIRA   = 7'h05;
    localparam logic [OFF_W-1:0] OFF_DIRB   = 7'h06;
    localparam logic [OFF_W-1:0] OFF_PCLATH = 7'h0A;
    localparam logic [OFF_W-1:0] OFF_INTCTL = 7'h0B;

    localparam logic [DATA_W-1:0] STATUS_POR = 8'h18;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_PCL, SEL_STATUS, SEL_PTR, SEL_PCLATH,
        SEL_INTCTL, SEL_OPTION, SEL_DIRA, SEL_DIRB
    } sfr_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] pcl;
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] ptr;
        logic [PCH_W-1:0]  pclath;
        logic [DATA_W-1:0] intctl;
        logic [DATA_W-1:0] option;
        logic [DIRA_W-1:0] dira;
        logic [DATA_W-1:0] dirb;
        logic [PCH_W-1:0]  pc_hi;
    } sfr_state_t;
endpackage

// File: rtl/sfr_addr_decode.sv
module sfr_addr_decode
    import sfr_pkg::*;
(
    input  logic [OFF_W-1:0]  off_i,
    input  logic              bank_i,
    input  logic [DATA_W-1:0] ptr_i,
    output sfr_sel_e          sel_o
);
    logic [ADDR_W-1:0] eff_addr;
    logic              bank_eff;
    logic [OFF_W-1:0]  off_eff;

    always_comb begin
        eff_addr = (off_i == OFF_IND) ? ptr_i : {bank_i, off_i};
        bank_eff = eff_addr[ADDR_W-1];
        off_eff  = eff_addr[OFF_W-1:0];
        sel_o    = SEL_NONE;
        if (off_eff != OFF_IND) begin
            case (off_eff)
                OFF_PCL:    sel_o = SEL_PCL;
                OFF_STATUS: sel_o = SEL_STATUS;
                OFF_PTR:    sel_o = SEL_PTR;
                OFF_PCLATH: sel_o = SEL_PCLATH;
                OFF_INTCTL: sel_o = SEL_INTCTL;
                default: begin
                    if (bank_eff) begin
                        case (off_eff)
                            OFF_OPTION: sel_o = SEL_OPTION;
                            OFF_DIRA:   sel_o = SEL_DIRA;
                            OFF_DIRB:   sel_o = SEL_DIRB;
                            default:    sel_o = SEL_NONE;
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sfr_regs.sv
module sfr_regs
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              por_i,
    input  logic              ext_rst_i,
    input  logic              wr_en_i,
    input  sfr_sel_e          sel_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              pc_load_i,
    output sfr_state_t        state_o
);
    sfr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (por_i) begin
            state_d        = '0;
            state_d.status = STATUS_POR;
            state_d.option = '1;
            state_d.dira   = '1;
            state_d.dirb   = '1;
        end else if (ext_rst_i) begin
            state_d.status = {{(DATA_W-ST_KEEP_HI-1){1'b0}}, state_q.status[ST_KEEP_HI:0]};
            state_d.intctl = {{(DATA_W-1){1'b0}}, state_q.intctl[0]};
            state_d.pcl    = '0;
            state_d.pclath = '0;
            state_d.pc_hi  = '0;
            state_d.option = '1;
            state_d.dira   = '1;
            state_d.dirb   = '1;
        end else begin
            if (wr_en_i) begin
                case (sel_i)
                    SEL_PCL:    state_d.pcl    = wr_data_i;
                    SEL_STATUS: state_d.status = wr_data_i;
                    SEL_PTR:    state_d.ptr    = wr_data_i;
                    SEL_PCLATH: state_d.pclath = wr_data_i[PCH_W-1:0];
                    SEL_INTCTL: state_d.intctl = wr_data_i;
                    SEL_OPTION: state_d.option = wr_data_i;
                    SEL_DIRA:   state_d.dira   = wr_data_i[DIRA_W-1:0];
                    SEL_DIRB:   state_d.dirb   = wr_data_i;
                    default:    state_d        = state_q;
                endcase
            end
            if (pc_load_i) state_d.pc_hi = state_q.pclath;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign state_o = state_q;

    // R8
    ext_keep_chk: assert property (@(posedge clk) disable iff (por_i)
        ext_rst_i |=> (state_q.status[ST_KEEP_HI:0] == $past(state_q.status[ST_KEEP_HI:0]))
                      && (state_q.status[DATA_W-1:ST_KEEP_HI+1] == '0)
                      && (state_q.ptr == $past(state_q.ptr)));

    // R9
    rst_over_wr_chk: assert property (@(posedge clk) disable iff (por_i)
        (ext_rst_i && (wr_en_i || pc_load_i)) |=> (state_q.pclath == '0) && (state_q.pc_hi == '0));

    // R6
    pchi_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (!ext_rst_i && !pc_load_i) |=> $stable(state_q.pc_hi));

    // R6
    pchi_load_chk: assert property (@(posedge clk) disable iff (por_i)
        (!ext_rst_i && pc_load_i) |=> (state_q.pc_hi == $past(state_q.pclath)));

    // R5
    no_effect_chk: assert property (@(posedge clk) disable iff (por_i)
        (!ext_rst_i && !pc_load_i && (!wr_en_i || sel_i == SEL_NONE)) |=> $stable(state_q));
endmodule

// File: rtl/sfr_read_mux.sv
module sfr_read_mux
    import sfr_pkg::*;
(
    input  sfr_sel_e          sel_i,
    input  sfr_state_t        state_i,
    output logic [DATA_W-1:0] rd_data_o
);
    always_comb begin
        case (sel_i)
            SEL_PCL:    rd_data_o = state_i.pcl;
            SEL_STATUS: rd_data_o = state_i.status;
            SEL_PTR:    rd_data_o = state_i.ptr;
            SEL_PCLATH: rd_data_o = {{(DATA_W-PCH_W){1'b0}}, state_i.pclath};
            SEL_INTCTL: rd_data_o = state_i.intctl;
            SEL_OPTION: rd_data_o = state_i.option;
            SEL_DIRA:   rd_data_o = {{(DATA_W-DIRA_W){1'b0}}, state_i.dira};
            SEL_DIRB:   rd_data_o = state_i.dirb;
            default:    rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/banked_sfr_file.sv
module banked_sfr_file
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              por_req,
    input  logic              pin_rst_req,
    input  logic              wdt_rst_req,
    input  logic [OFF_W-1:0]  addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pc_load,
    output logic [PC_W-1:0]   pc_full
);
    sfr_state_t state;
    sfr_sel_e   sel;
    logic       ext_rst;

    assign ext_rst = pin_rst_req | wdt_rst_req;

    sfr_addr_decode u_decode (
        .off_i  (addr),
        .bank_i (state.status[ST_BANK]),
        .ptr_i  (state.ptr),
        .sel_o  (sel)
    );

    sfr_regs u_regs (
        .clk       (clk),
        .por_i     (por_req),
        .ext_rst_i (ext_rst),
        .wr_en_i   (wr_en),
        .sel_i     (sel),
        .wr_data_i (wr_data),
        .pc_load_i (pc_load),
        .state_o   (state)
    );

    sfr_read_mux u_rmux (
        .sel_i     (sel),
        .state_i   (state),
        .rd_data_o (rd_data)
    );

    assign pc_full = {state.pc_hi, state.pcl};

    // R4
    null_read_chk: assert property (@(posedge clk) disable iff (por_req)
        ((addr == OFF_IND) && (state.ptr[OFF_W-1:0] == '0)) |-> (rd_data == '0));

    // R6
    latch_upper_zero_chk: assert property (@(posedge clk) disable iff (por_req)
        (sel == SEL_PCLATH) |-> (rd_data[DATA_W-1:PCH_W] == '0));
endmodule

// File: tb/banked_sfr_file_tb.sv
module banked_sfr_file_tb;
    logic        clk = 1'b0;
    logic        por_req = 1'b1, pin_rst_req = 1'b0, wdt_rst_req = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0, pc_load = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [12:0] pc_full;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model
    logic [7:0] m_pcl, m_status, m_ptr, m_intctl, m_option, m_dirb;
    logic [4:0] m_pclath, m_dira, m_pchi;

    always #10 clk = ~clk;

    banked_sfr_file u_dut (
        .clk(clk), .por_req(por_req), .pin_rst_req(pin_rst_req), .wdt_rst_req(wdt_rst_req),
        .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pc_load(pc_load), .pc_full(pc_full)
    );

    function automatic logic [7:0] eff_of(input logic [6:0] off);
        return (off == 7'h00) ? m_ptr : {m_status[5], off};
    endfunction

    function automatic logic [7:0] exp_read(input logic [6:0] off);
        logic [7:0] ea;
        ea = eff_of(off);
        if (ea[6:0] == 7'h00) return 8'h00;
        case (ea[6:0])
            7'h02: return m_pcl;
            7'h03: return m_status;
            7'h04: return m_ptr;
            7'h0A: return {3'b000, m_pclath};
            7'h0B: return m_intctl;
            7'h01: return ea[7] ? m_option : 8'h00;
            7'h05: return ea[7] ? {3'b000, m_dira} : 8'h00;
            7'h06: return ea[7] ? m_dirb : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(input logic [6:0] off, input logic [7:0] d);
        logic [7:0] ea;
        ea = eff_of(off);
        if (ea[6:0] == 7'h00) return;
        case (ea[6:0])
            7'h02: m_pcl = d;
            7'h03: m_status = d;
            7'h04: m_ptr = d;
            7'h0A: m_pclath = d[4:0];
            7'h0B: m_intctl = d;
            7'h01: if (ea[7]) m_option = d;
            7'h05: if (ea[7]) m_dira = d[4:0];
            7'h06: if (ea[7]) m_dirb = d;
            default: ;
        endcase
    endfunction

    function automatic void model_por();
        m_pcl = 0; m_status = 8'h18; m_ptr = 0; m_pclath = 0; m_intctl = 0;
        m_option = 8'hFF; m_dira = 5'h1F; m_dirb = 8'hFF; m_pchi = 0;
    endfunction

    function automatic void model_ext();
        m_status = {3'b000, m_status[4:0]}; m_intctl = {7'd0, m_intctl[0]};
        m_pcl = 0; m_pclath = 0; m_pchi = 0;
        m_option = 8'hFF; m_dira = 5'h1F; m_dirb = 8'hFF;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_drive();
        por_req = 0; pin_rst_req = 0; wdt_rst_req = 0; wr_en = 0; pc_load = 0;
    endtask

    task automatic wr(input logic [6:0] off, input logic [7:0] d);
        @(negedge clk); idle_drive(); addr = off; wr_data = d; wr_en = 1;
        @(posedge clk); model_write(off, d);
    endtask

    task automatic rd_chk(input logic [6:0] off, input string tag);
        @(negedge clk); idle_drive(); addr = off;
        #2;
        check(tag, {8'h00, rd_data}, {8'h00, exp_read(off)});
        check({tag, " pc"}, {3'b000, pc_full}, {3'b000, m_pchi, m_pcl});
    endtask

    task automatic do_load();
        @(negedge clk); idle_drive(); pc_load = 1;
        @(posedge clk); m_pchi = m_pclath;
    endtask

    // kind: 0 pin, 1 watchdog, 2 power-on; optional same-cycle write
    task automatic do_rst(input int kind, input bit with_wr, input logic [6:0] off, input logic [7:0] d);
        @(negedge clk); idle_drive();
        addr = off; wr_data = d; wr_en = with_wr; pc_load = with_wr;
        if (kind == 0) pin_rst_req = 1;
        else if (kind == 1) wdt_rst_req = 1;
        else por_req = 1;
        @(posedge clk);
        if (kind == 2) model_por(); else model_ext();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1215));
        repeat (2) @(posedge clk);
        model_por();
        // R7 reset state
        rd_chk(7'h03, "R7 status");
        rd_chk(7'h02, "R7 pcl");
        rd_chk(7'h04, "R7 ptr");
        rd_chk(7'h0A, "R7 pclath");
        rd_chk(7'h0B, "R7 intctl");
        // R1 bank select, R7 bank-1 values
        wr(7'h03, 8'h38);
        rd_chk(7'h01, "R1 R7 option");
        rd_chk(7'h05, "R1 R7 dira");
        rd_chk(7'h06, "R1 R7 dirb");
        rd_chk(7'h03, "R2 status mirror");
        wr(7'h01, 8'hA5);
        rd_chk(7'h01, "R1 option write");
        wr(7'h03, 8'h18);
        rd_chk(7'h01, "R1 bank0 offset01");
        // R5 unimplemented
        wr(7'h07, 8'hFF);
        rd_chk(7'h07, "R5 07h");
        wr(7'h03, 8'h38);
        wr(7'h07, 8'hFF);
        rd_chk(7'h07, "R5 87h");
        rd_chk(7'h01, "R5 option untouched");
        wr(7'h03, 8'h18);
        // R3 indirect, ignores bank bit
        wr(7'h04, 8'h81);
        rd_chk(7'h00, "R3 indirect option");
        wr(7'h00, 8'h3C);
        rd_chk(7'h00, "R3 indirect write");
        wr(7'h04, 8'h8A);
        wr(7'h00, 8'hFF);
        rd_chk(7'h0A, "R2 R3 R6 pclath upper zero");
        // R4 null pointer
        wr(7'h04, 8'h80);
        wr(7'h00, 8'h55);
        rd_chk(7'h00, "R4 null read");
        rd_chk(7'h04, "R4 ptr kept");
        rd_chk(7'h0A, "R4 pclath kept");
        // R6 load path
        wr(7'h02, 8'h34);
        rd_chk(7'h02, "R6 before load");
        do_load();
        rd_chk(7'h02, "R6 after load");
        wr(7'h0A, 8'h05);
        rd_chk(7'h0A, "R6 no copy back");
        // R10 timing
        @(negedge clk); idle_drive(); addr = 7'h0B; wr_data = 8'hFF; wr_en = 1;
        #2 check("R10 before edge", {8'h00, rd_data}, {8'h00, m_intctl});
        @(posedge clk); model_write(7'h0B, 8'hFF);
        #2 check("R10 after edge", {8'h00, rd_data}, 16'h00FF);
        // R8 pin reset
        wr(7'h03, 8'h27);
        wr(7'h01, 8'h00); wr(7'h05, 8'h00); wr(7'h06, 8'h00);
        do_rst(0, 0, 7'h00, 8'h00);
        rd_chk(7'h03, "R8 status");
        rd_chk(7'h0B, "R8 intctl");
        rd_chk(7'h04, "R8 ptr kept");
        rd_chk(7'h0A, "R8 pclath");
        wr(7'h04, 8'h81); rd_chk(7'h00, "R8 option");
        wr(7'h04, 8'h85); rd_chk(7'h00, "R8 dira");
        wr(7'h04, 8'h86); rd_chk(7'h00, "R8 dirb");
        // R9 reset beats write / load
        wr(7'h0A, 8'h1B); do_load(); wr(7'h0A, 8'h0C);
        do_rst(1, 1, 7'h0A, 8'h1F);
        rd_chk(7'h0A, "R9 watchdog over write");
        wr(7'h03, 8'h07);
        do_rst(2, 1, 7'h03, 8'hE0);
        rd_chk(7'h03, "R9 por over write");
        // random mix
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [6:0] off;
            r = $urandom % 16;
            case ($urandom % 4)
                0: off = $urandom;
                default: begin
                    case ($urandom % 9)
                        0: off = 7'h00; 1: off = 7'h01; 2: off = 7'h02; 3: off = 7'h03;
                        4: off = 7'h04; 5: off = 7'h05; 6: off = 7'h06; 7: off = 7'h0A;
                        default: off = 7'h0B;
                    endcase
                end
            endcase
            if (r == 0) do_rst(0, $urandom % 2, off, 8'($urandom));
            else if (r == 1) do_rst(1, $urandom % 2, off, 8'($urandom));
            else if (r == 2) do_load();
            else if (r < 9) wr(off, 8'($urandom));
            rd_chk(off, "R1 R2 R3 R4 R5 R6 R8 R10 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule